// File: doc/BRIEF.md
# Serial Port Pin Multiplexer

This block controls an eight-pin port shared by a synchronous serial engine (master or slave), an asynchronous serial transmitter and plain general-purpose I/O. Three 8-bit registers sit behind a small word-wide register bus with byte enables:

- a function-select register, which says whether each pin is general-purpose or belongs to the synchronous engine;
- a direction register;
- a port-data latch.

From these registers, the engine mode and the peripheral enables, a purely combinational router works out three things for every pin: whether it is driven, what value it drives, and which engine input it feeds.

In a serial function the direction bit does not always mean "input or output". Depending on the pin and the mode, it can also disable the pin altogether. The synchronous enable and the transmitter enable take precedence over both the function-select and the direction registers.

When the engine is a master, the select pin can be configured as an input. If another device then pulls it low, the block records a mode fault. A small two-state machine keeps that fault until software clears it:

- `FLT_CLEAR` moves to `FLT_LATCHED` on transition *detect*, when the fault condition is seen at a clock edge.
- `FLT_LATCHED` returns to `FLT_CLEAR` on transition *clear*, when a clear write arrives while the condition is absent.
- Otherwise each state holds.

Pin roles by index: 0 serial data-in, 1 serial data-out, 2 serial clock, 3 select (slave-select input, or chip-select 0 output), 4..6 chip-selects 1..3, 7 asynchronous transmit data.

Top module: `sport_pinmux`

## Requirements
- R1: After reset, all three registers read zero, every `pin_oe` bit is 0 and `mode_fault` is 0.
- R2: Word address 0 holds the function-select register in bits 15:8 and the direction register in bits 7:0. `bus_be[1]` writes the upper byte and `bus_be[0]` the lower byte. A write takes effect at the next clock edge, and a lane whose enable is 0 is unchanged.
- R3: A pin with function-select 0 (pins 0,1,3..6) is general-purpose: `pin_oe` equals its direction bit and `pin_out` equals its port-data bit. The port-data latch is written in bits 7:0 of word address 1. Reading word 1 bits 7:0 returns the live `pin_in` levels, not the latch.
- R4: While `sci_tx_en`=1, pin 7 is driven (`pin_oe[7]`=1) with `sci_txd`, regardless of its direction bit. While `sci_tx_en`=0, pin 7 is general-purpose per R3 even if its function-select bit is 1.
- R5: Pin 2 is general-purpose while `spi_en`=0, whatever its function-select bit. With `spi_en`=1 the pin depends on mode and direction:
  - master, direction 1: drives `eng_sck`;
  - master, direction 0: disabled (not driven);
  - slave, direction 0: `pin_in[2]` goes to `eng_sck_in`;
  - slave, direction 1: disabled, and `eng_sck_in` reads 0.
- R6: Master mode, pins 0 and 1 with function-select 1:
  - pin 0, direction 0: input to `eng_sdi`;
  - pin 0, direction 1: disabled, and `eng_sdi` reads 0;
  - pin 1, direction 1: drives `eng_sdo`;
  - pin 1, direction 0: not driven.
- R7: Slave mode, pins 0 and 1 with function-select 1:
  - pin 1, direction 0: input to `eng_sdi`;
  - pin 1, direction 1: disabled, and `eng_sdi` reads 0;
  - pin 0, direction 1: drives `eng_sdo`;
  - pin 0, direction 0: not driven.
- R8: Master mode, pin 3 with function-select 1. Direction 1 drives `eng_cs[0]`. Direction 0 makes the pin an input. In that input state, with `spi_en`=1, a low `pin_in[3]` sets `mode_fault` at the next clock edge.
- R9: Slave mode, pin 3 with function-select 1. Direction 0 passes `pin_in[3]` to `eng_ss_n` (active low). Direction 1 leaves the pin undriven and holds `eng_ss_n` at 1. No mode fault is raised in slave mode.
- R10: Pins 4..6 with function-select 1 drive `eng_cs[1..3]` in master mode when their direction bit is 1. They are undriven in master mode with direction 0, and always undriven in slave mode.
- R11: The fault flag reads at word 1 bit 8 and also appears on `mode_fault`. It stays set after the condition goes away. A write to word 1 with `bus_be[1]`=1 and `bus_wdata[8]`=1 clears it at the next edge, unless the condition is still present, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word address (0 select/direction, 1 data/status) |
| bus_be | input | 2 | Byte enables, bit 1 = bits 15:8 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| spi_en | input | 1 | Synchronous serial engine enable |
| master | input | 1 | 1 = engine is master, 0 = slave |
| sci_tx_en | input | 1 | Asynchronous transmitter enable |
| sci_txd | input | 1 | Transmitter serial output |
| eng_sdo | input | 1 | Engine serial data output |
| eng_sck | input | 1 | Engine clock output (master) |
| eng_cs | input | 4 | Engine chip-select outputs 0..3 |
| eng_sdi | output | 1 | Serial data to engine |
| eng_sck_in | output | 1 | Serial clock to engine (slave) |
| eng_ss_n | output | 1 | Slave-select to engine, active low |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
The routing is tried with every mode and direction combination on each role pin: master and slave, direction 0 and 1. For each combination the bench checks both the drive enable and the engine input. This tells a pin that is an input apart from one that is disabled, because a disabled input returns its idle value even when the pin toggles.

General-purpose patterns use a port-data value that differs from the pin levels, so a read that returns the latch is told apart from one that returns the live pins. The enable overrides are tried with conflicting function-select and direction bits.

The fault is driven through three cases: set then released, cleared, and cleared while the condition is still present. These separate a sticky flag from a level copy of the condition, and a clear that wins from one that loses.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int PORT_W   = 8;
    localparam int BUS_W    = 2 * PORT_W;
    localparam int NCS      = 4;
    localparam int PIN_DIN  = 0;
    localparam int PIN_DOUT = 1;
    localparam int PIN_SCK  = 2;
    localparam int PIN_SEL0 = 3;
    localparam int PIN_CS1  = 4;
    localparam int PIN_TXD  = 7;
    localparam int FLT_BIT  = PORT_W;

    typedef enum logic [0:0] {
        FLT_CLEAR   = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_t;

    typedef struct packed {
        logic [PORT_W-1:0] fsel;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
    } port_cfg_t;
endpackage

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [1:0]       bus_be,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic             fault_flag,
    output port_cfg_t        cfg,
    output logic             fault_clr,
    output logic [BUS_W-1:0] bus_rdata
);
    port_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            if (!bus_addr) begin
                if (bus_be[1]) cfg_q.fsel <= bus_wdata[BUS_W-1:PORT_W];
                if (bus_be[0]) cfg_q.dir  <= bus_wdata[PORT_W-1:0];
            end else if (bus_be[0]) begin
                cfg_q.lat <= bus_wdata[PORT_W-1:0];
            end
        end
    end

    assign cfg       = cfg_q;
    assign fault_clr = bus_wr && bus_addr && bus_be[1] && bus_wdata[FLT_BIT];

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata = {cfg_q.fsel, cfg_q.dir};
        end else begin
            bus_rdata[PORT_W-1:0] = pin_in;
            bus_rdata[FLT_BIT]    = fault_flag;
        end
    end

    // R2: an upper-lane write to word 0 lands in the function-select register
    p_fsel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_be[1]) |=> cfg_q.fsel == $past(bus_wdata[BUS_W-1:PORT_W]));

    // R2: a lane left disabled keeps its value
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_addr && bus_be[0]) |=> $stable(cfg_q.dir));
endmodule

// File: rtl/sport_fault_fsm.sv
module sport_fault_fsm
    import sport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_cond,
    input  logic fault_clr,
    output logic fault_flag
);
    flt_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR:   if (fault_cond)                state_d = FLT_LATCHED;
            FLT_LATCHED: if (fault_clr && !fault_cond)  state_d = FLT_CLEAR;
            default:                                    state_d = FLT_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLT_LATCHED: fault_flag = 1'b1;
            default:     fault_flag = 1'b0;
        endcase
    end

    // R8: the condition raises the flag one edge later
    p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> fault_flag);

    // R11: without a clear the flag is kept
    p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag);

    // R11: a clear while the condition is absent drops the flag
    p_fault_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && fault_clr && !fault_cond) |=> !fault_flag);
endmodule

// File: rtl/sport_route.sv
module sport_route
    import sport_pkg::*;
(
    input  port_cfg_t         cfg,
    input  logic              spi_en,
    input  logic              master,
    input  logic              sci_tx_en,
    input  logic              sci_txd,
    input  logic              eng_sdo,
    input  logic              eng_sck,
    input  logic [NCS-1:0]    eng_cs,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              eng_sdi,
    output logic              eng_sck_in,
    output logic              eng_ss_n,
    output logic              fault_cond
);
    logic [NCS-2:0] cs_out, cs_oe, cs_ser;

    for (genvar k = 1; k < NCS; k++) begin : g_cs
        localparam int P = PIN_CS1 + k - 1;
        assign cs_ser[k-1] = cfg.fsel[P];
        assign cs_oe[k-1]  = cfg.fsel[P] ? (master && cfg.dir[P]) : cfg.dir[P];
        assign cs_out[k-1] = cfg.fsel[P] ? (master && cfg.dir[P] && eng_cs[k]) : cfg.lat[P];
    end

    always_comb begin
        pin_out = cfg.lat;
        pin_oe  = cfg.dir;

        if (cfg.fsel[PIN_DIN]) begin
            pin_oe[PIN_DIN]  = !master && cfg.dir[PIN_DIN];
            pin_out[PIN_DIN] = pin_oe[PIN_DIN] && eng_sdo;
        end
        if (cfg.fsel[PIN_DOUT]) begin
            pin_oe[PIN_DOUT]  = master && cfg.dir[PIN_DOUT];
            pin_out[PIN_DOUT] = pin_oe[PIN_DOUT] && eng_sdo;
        end
        if (spi_en) begin
            pin_oe[PIN_SCK]  = master && cfg.dir[PIN_SCK];
            pin_out[PIN_SCK] = pin_oe[PIN_SCK] && eng_sck;
        end
        if (cfg.fsel[PIN_SEL0]) begin
            pin_oe[PIN_SEL0]  = master && cfg.dir[PIN_SEL0];
            pin_out[PIN_SEL0] = pin_oe[PIN_SEL0] && eng_cs[0];
        end
        pin_oe[PIN_CS1 +: NCS-1]  = cs_oe;
        pin_out[PIN_CS1 +: NCS-1] = cs_out;
        if (sci_tx_en) begin
            pin_oe[PIN_TXD]  = 1'b1;
            pin_out[PIN_TXD] = sci_txd;
        end
    end

    always_comb begin
        if (master)
            eng_sdi = cfg.fsel[PIN_DIN] && !cfg.dir[PIN_DIN] && pin_in[PIN_DIN];
        else
            eng_sdi = cfg.fsel[PIN_DOUT] && !cfg.dir[PIN_DOUT] && pin_in[PIN_DOUT];

        eng_sck_in = spi_en && !master && !cfg.dir[PIN_SCK] && pin_in[PIN_SCK];

        if (!master && cfg.fsel[PIN_SEL0] && !cfg.dir[PIN_SEL0])
            eng_ss_n = pin_in[PIN_SEL0];
        else
            eng_ss_n = 1'b1;

        fault_cond = spi_en && master && cfg.fsel[PIN_SEL0]
                     && !cfg.dir[PIN_SEL0] && !pin_in[PIN_SEL0];
    end

    // R10: chip-select pins never drive in slave mode
    p_cs_slave_quiet_r10: assert final (master || (cs_oe & cs_ser) == '0);
endmodule

// File: rtl/sport_pinmux.sv
module sport_pinmux
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              spi_en,
    input  logic              master,
    input  logic              sci_tx_en,
    input  logic              sci_txd,
    input  logic              eng_sdo,
    input  logic              eng_sck,
    input  logic [NCS-1:0]    eng_cs,
    output logic              eng_sdi,
    output logic              eng_sck_in,
    output logic              eng_ss_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              mode_fault
);
    port_cfg_t cfg;
    logic      fault_clr, fault_cond, fault_flag;

    sport_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .pin_in(pin_in),
        .fault_flag(fault_flag), .cfg(cfg), .fault_clr(fault_clr),
        .bus_rdata(bus_rdata)
    );

    sport_route u_route (
        .cfg(cfg), .spi_en(spi_en), .master(master), .sci_tx_en(sci_tx_en),
        .sci_txd(sci_txd), .eng_sdo(eng_sdo), .eng_sck(eng_sck), .eng_cs(eng_cs),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .eng_sdi(eng_sdi),
        .eng_sck_in(eng_sck_in), .eng_ss_n(eng_ss_n), .fault_cond(fault_cond)
    );

    sport_fault_fsm u_fault (
        .clk(clk), .rst_n(rst_n), .fault_cond(fault_cond),
        .fault_clr(fault_clr), .fault_flag(fault_flag)
    );

    assign mode_fault = fault_flag;

    // R4: an enabled transmitter always owns pin 7
    p_txd_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sci_tx_en |-> (pin_oe[PIN_TXD] && pin_out[PIN_TXD] == sci_txd));

    // R9: slave mode never reports a mode fault edge
    p_no_slave_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !mode_fault) |=> !mode_fault || $past(master) );

    // R5: with the engine off the clock pin follows the general-purpose settings
    p_sck_gpio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (eng_sck_in == 1'b0));
endmodule

// File: tb/sport_pinmux_test.sv
module sport_pinmux_test;
    import sport_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_addr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        spi_en = 1'b0, master = 1'b0, sci_tx_en = 1'b0, sci_txd = 1'b0;
    logic        eng_sdo = 1'b0, eng_sck = 1'b0;
    logic [3:0]  eng_cs = '0;
    logic        eng_sdi, eng_sck_in, eng_ss_n, mode_fault;
    logic [7:0]  pin_in = 8'hFF, pin_out, pin_oe;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sport_pinmux uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_en(spi_en), .master(master), .sci_tx_en(sci_tx_en), .sci_txd(sci_txd),
        .eng_sdo(eng_sdo), .eng_sck(eng_sck), .eng_cs(eng_cs), .eng_sdi(eng_sdi),
        .eng_sck_in(eng_sck_in), .eng_ss_n(eng_ss_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .mode_fault(mode_fault)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
        #1;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(1'b0, d); chk("R1 select/dir reset", d, 16'h0000);
        rd(1'b1, d); chk("R1 fault bit reset", {15'b0, d[8]}, 16'h0000);
        chk("R1 oe reset", {8'h00, pin_oe}, 16'h0000);
        chk("R1 mode_fault reset", {15'b0, mode_fault}, 16'h0000);
    endtask

    task automatic t_bus();
        logic [15:0] d;
        wr(1'b0, 2'b10, 16'hA53C);
        rd(1'b0, d); chk("R2 upper lane only", d, 16'hA500);
        wr(1'b0, 2'b01, 16'h11C3);
        rd(1'b0, d); chk("R2 lower lane only", d, 16'hA5C3);
        wr(1'b0, 2'b11, 16'h0000);
        rd(1'b0, d); chk("R2 both lanes", d, 16'h0000);
    endtask

    task automatic t_gpio();
        logic [15:0] d;
        wr(1'b0, 2'b11, 16'h000F);
        wr(1'b1, 2'b01, 16'h005A);
        chk("R3 gpio oe", {8'h00, pin_oe}, 16'h000F);
        chk("R3 gpio out", {8'h00, pin_out}, 16'h005A);
        pin_in = 8'h96;
        rd(1'b1, d); chk("R3 read returns pins", {8'h00, d[7:0]}, 16'h0096);
        pin_in = 8'hFF;
    endtask

    task automatic t_txd();
        wr(1'b0, 2'b11, 16'h8000);
        wr(1'b1, 2'b01, 16'h0080);
        sci_tx_en = 1'b0; settle();
        chk("R4 fsel ignored, gpio input", {14'b0, pin_oe[7], pin_out[7]}, 16'h0001);
        sci_tx_en = 1'b1; sci_txd = 1'b0; settle();
        chk("R4 tx forces drive 0", {14'b0, pin_oe[7], pin_out[7]}, 16'h0002);
        sci_txd = 1'b1; settle();
        chk("R4 tx forces drive 1", {14'b0, pin_oe[7], pin_out[7]}, 16'h0003);
        wr(1'b1, 2'b01, 16'h0000);
        sci_tx_en = 1'b0; sci_txd = 1'b0;
        wr(1'b0, 2'b11, 16'h0000);
    endtask

    task automatic t_clock();
        wr(1'b0, 2'b11, 16'h0404);
        wr(1'b1, 2'b01, 16'h0004);
        spi_en = 1'b0; settle();
        chk("R5 gpio when engine off", {14'b0, pin_oe[2], pin_out[2]}, 16'h0003);
        spi_en = 1'b1; master = 1'b1; eng_sck = 1'b0; settle();
        chk("R5 master drives sck 0", {14'b0, pin_oe[2], pin_out[2]}, 16'h0002);
        eng_sck = 1'b1; settle();
        chk("R5 master drives sck 1", {14'b0, pin_oe[2], pin_out[2]}, 16'h0003);
        wr(1'b0, 2'b01, 16'h0000);
        chk("R5 master dir0 disabled", {15'b0, pin_oe[2]}, 16'h0000);
        master = 1'b0; pin_in[2] = 1'b1; settle();
        chk("R5 slave sck input", {14'b0, pin_oe[2], eng_sck_in}, 16'h0001);
        wr(1'b0, 2'b01, 16'h0004);
        chk("R5 slave dir1 disabled", {14'b0, pin_oe[2], eng_sck_in}, 16'h0000);
        spi_en = 1'b0; eng_sck = 1'b0;
        wr(1'b1, 2'b01, 16'h0000);
    endtask

    task automatic t_master_data();
        spi_en = 1'b1; master = 1'b1; eng_sdo = 1'b1;
        wr(1'b0, 2'b11, 16'h0302);
        chk("R6 master dout drives", {14'b0, pin_oe[1:0]}, 16'h0002);
        chk("R6 master dout value", {15'b0, pin_out[1]}, 16'h0001);
        pin_in[0] = 1'b1; settle();
        chk("R6 master din input 1", {15'b0, eng_sdi}, 16'h0001);
        pin_in[0] = 1'b0; settle();
        chk("R6 master din input 0", {15'b0, eng_sdi}, 16'h0000);
        wr(1'b0, 2'b01, 16'h0001);
        pin_in[0] = 1'b1; settle();
        chk("R6 master swapped dirs disabled", {13'b0, pin_oe[1:0], eng_sdi}, 16'h0000);
    endtask

    task automatic t_slave_data();
        master = 1'b0; eng_sdo = 1'b1;
        wr(1'b0, 2'b11, 16'h0301);
        chk("R7 slave din drives sdo", {14'b0, pin_oe[1:0]}, 16'h0001);
        chk("R7 slave din value", {15'b0, pin_out[0]}, 16'h0001);
        pin_in[1] = 1'b1; settle();
        chk("R7 slave dout input", {15'b0, eng_sdi}, 16'h0001);
        wr(1'b0, 2'b01, 16'h0002);
        chk("R7 slave swapped dirs disabled", {13'b0, pin_oe[1:0], eng_sdi}, 16'h0000);
        eng_sdo = 1'b0; pin_in = 8'hFF;
        wr(1'b0, 2'b11, 16'h0000);
    endtask

    task automatic t_select();
        logic [15:0] d;
        master = 1'b1; spi_en = 1'b1; eng_cs = 4'b1110;
        wr(1'b0, 2'b11, 16'h0808);
        chk("R8 master cs0 drives 0", {14'b0, pin_oe[3], pin_out[3]}, 16'h0002);
        eng_cs = 4'b1111; settle();
        chk("R8 master cs0 drives 1", {14'b0, pin_oe[3], pin_out[3]}, 16'h0003);
        wr(1'b0, 2'b01, 16'h0000);
        pin_in[3] = 1'b1;
        @(negedge clk); #1;
        chk("R8 high select no fault", {14'b0, pin_oe[3], mode_fault}, 16'h0000);
        pin_in[3] = 1'b0;
        @(negedge clk); #1;
        rd(1'b1, d); chk("R8 low select sets fault", {14'b0, d[8], mode_fault}, 16'h0003);
        pin_in[3] = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        chk("R11 fault sticky", {15'b0, mode_fault}, 16'h0001);
        wr(1'b1, 2'b10, 16'h0100);
        chk("R11 fault cleared", {15'b0, mode_fault}, 16'h0000);
        pin_in[3] = 1'b0;
        @(negedge clk); #1;
        wr(1'b1, 2'b10, 16'h0100);
        chk("R11 clear loses to live condition", {15'b0, mode_fault}, 16'h0001);
        pin_in[3] = 1'b1;
        wr(1'b1, 2'b10, 16'h0100);
        chk("R11 clear after release", {15'b0, mode_fault}, 16'h0000);
    endtask

    task automatic t_slave_select();
        master = 1'b0; spi_en = 1'b1;
        wr(1'b0, 2'b11, 16'h0800);
        pin_in[3] = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        chk("R9 slave select input", {14'b0, eng_ss_n, mode_fault}, 16'h0000);
        wr(1'b0, 2'b01, 16'h0008);
        chk("R9 slave dir1 disabled", {14'b0, pin_oe[3], eng_ss_n}, 16'h0001);
        pin_in = 8'hFF;
    endtask

    task automatic t_cs();
        master = 1'b1; eng_cs = 4'b1010;
        wr(1'b0, 2'b11, 16'h7070);
        chk("R10 master cs oe", {13'b0, pin_oe[6:4]}, 16'h0007);
        chk("R10 master cs values", {13'b0, pin_out[6:4]}, 16'h0005);
        wr(1'b0, 2'b01, 16'h0000);
        chk("R10 master dir0 disabled", {13'b0, pin_oe[6:4]}, 16'h0000);
        master = 1'b0;
        wr(1'b0, 2'b01, 16'h0070);
        chk("R10 slave cs inactive", {13'b0, pin_oe[6:4]}, 16'h0000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_bus();
        t_gpio();
        wr(1'b0, 2'b11, 16'h0000);
        wr(1'b1, 2'b01, 16'h0000);
        t_txd();
        t_clock();
        t_master_data();
        t_slave_data();
        t_select();
        t_slave_select();
        t_cs();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule